// File: doc/BRIEF.md
# Bus machine-cycle sequencer

This block runs a single bus machine cycle for an 8-bit processor whose data lines carry a status byte first and data afterwards. A request names one of eight cycle kinds and gives an address. The block then steps through the states T1, T2, any number of wait states (Tw) and T3, one state per clock. Each clock edge stands for the phi2 rising edge of a two-phase clock.

In T1 it drives the address, pulses SYNC and puts a status byte on the data lines. From T2 onward the data lines carry the outgoing byte in a write cycle. In a read cycle the lines are released and DBIN is raised. READY is sampled at the end of T2 and at the end of each wait state. A low READY holds the cycle in Tw with WAIT raised. In read and input cycles the incoming byte is captured at the end of T3. The block then gives a one-clock completion pulse together with the captured byte and a flag that tells instruction bytes from data bytes.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request presented in idle is taken at a clock edge. The next clock is T1, and T2 follows. With READY high at the end of T2, the clock after T2 is T3. `done_o` is high in the clock after T3, which is the fourth clock after the accepting edge plus one clock per wait state.
- R2: In T1 `sync_o` is high and `dout_oe_o` is high. `dout_o` then carries the status byte: bit7 memory read, bit6 input, bit5 first fetch, bit4 output, bit3 halt acknowledge (always 0 here), bit2 stack, bit1 write active-low, bit0 interrupt acknowledge. This gives 0xA2 for fetch, 0x82 for memory read, 0x00 for memory write, 0x86 for stack read, 0x04 for stack write, 0x42 for input, 0x10 for output and 0x23 for interrupt acknowledge. The `ctype_i` codes are 0 fetch, 1 memory read, 2 memory write, 3 stack read, 4 stack write, 5 input, 6 output, 7 interrupt acknowledge. `sync_o` is low in every other clock.
- R3: In write cycles (codes 2, 4, 6), `dout_oe_o` is high and `dout_o` equals the write byte taken with the request, from T2 through T3.
- R4: `dbin_o` is high from T2 through T3 only in fetch, memory read, stack read and interrupt acknowledge cycles. It is low in every other clock.
- R5: A low `ready_i` at the end of T2 or of a Tw inserts one more Tw. `wait_o` is high exactly in Tw clocks, and each Tw lengthens `dbin_o` by one clock.
- R6: In fetch, memory read, stack read, interrupt acknowledge and input cycles, `din_i` is captured at the end of T3 into `rdata_o`. `rdata_instr_o` is set to 1 for fetch and to 0 for the other four kinds.
- R7: Write cycles leave `rdata_o` and `rdata_instr_o` unchanged.
- R8: `dout_oe_o` is low in idle and from T2 through T3 of non-write cycles.
- R9: `done_o` lasts one clock. A request raised while a cycle is in progress is ignored and does not start a new T1.
- R10: An active-low reset returns the block to idle with `sync_o`, `dbin_o`, `wait_o`, `dout_oe_o` and `done_o` low and `rdata_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per phi2 rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a machine cycle |
| ctype_i | input | 3 | Cycle kind code |
| addr_i | input | ADDR_W | Cycle address |
| wdata_i | input | DATA_W | Byte to write |
| ready_i | input | 1 | Target ready, sampled at the end of T2 and Tw |
| din_i | input | DATA_W | Data lines in |
| addr_o | output | ADDR_W | Address lines |
| sync_o | output | 1 | Marks T1 |
| dbin_o | output | 1 | Data bus input enable |
| wait_o | output | 1 | High in wait states |
| dout_o | output | DATA_W | Data lines out (status or write byte) |
| dout_oe_o | output | 1 | Data lines output enable |
| done_o | output | 1 | Cycle complete pulse |
| rdata_o | output | DATA_W | Captured byte |
| rdata_instr_o | output | 1 | Captured byte is an instruction |

## Verification
The bench builds the block with its default 16-bit address and 8-bit data. It covers all eight cycle kinds against zero to three wait states, so every status byte and every stretch of DBIN and WAIT is checked clock by clock. Requests raised mid-cycle, write cycles that follow reads (to check that the captured byte is held) and a reset in the middle of a cycle are also in reach with this small setup.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  typedef enum logic [2:0] {
    CT_FETCH = 3'd0, CT_MRD = 3'd1, CT_MWR = 3'd2, CT_SRD = 3'd3,
    CT_SWR   = 3'd4, CT_IN  = 3'd5, CT_OUT = 3'd6, CT_INTA = 3'd7
  } cyc_type_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3
  } bus_state_e;

  function automatic logic is_write(cyc_type_e t);
    return (t == CT_MWR) || (t == CT_SWR) || (t == CT_OUT);
  endfunction

  function automatic logic uses_dbin(cyc_type_e t);
    return (t == CT_FETCH) || (t == CT_MRD) || (t == CT_SRD) || (t == CT_INTA);
  endfunction

  function automatic logic takes_data(cyc_type_e t);
    return uses_dbin(t) || (t == CT_IN);
  endfunction
endpackage

// File: rtl/bus_status_enc.sv
module bus_status_enc
  import bus_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  cyc_type_e          ctype_i,
  output logic [DATA_W-1:0]  status_o
);
  localparam int STAT_W = 8;
  logic [STAT_W-1:0] st;

  always_comb begin
    st    = '0;
    st[0] = (ctype_i == CT_INTA);
    st[1] = !is_write(ctype_i);
    st[2] = (ctype_i == CT_SRD) || (ctype_i == CT_SWR);
    st[3] = 1'b0;
    st[4] = (ctype_i == CT_OUT);
    st[5] = (ctype_i == CT_FETCH) || (ctype_i == CT_INTA);
    st[6] = (ctype_i == CT_IN);
    st[7] = (ctype_i == CT_FETCH) || (ctype_i == CT_MRD) || (ctype_i == CT_SRD);
  end

  generate
    if (DATA_W > STAT_W) begin : g_wide
      assign status_o = {{(DATA_W-STAT_W){1'b0}}, st};
    end else begin : g_narrow
      assign status_o = st[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/bus_cyc_fsm.sv
module bus_cyc_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       ready_i,
  output bus_state_e state_o,
  output logic       accept_o,
  output logic       done_o
);
  bus_state_e state_q, state_d;
  logic       done_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2,
      ST_TW:   state_d = ready_i ? ST_T3 : ST_TW;
      ST_T3:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_T3);
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  p_t1_then_t2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_T1 |=> state_q == ST_T2);
  p_wait_on_low_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_T2 || state_q == ST_TW) && !ready_i |=> state_q == ST_TW);
  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != ST_IDLE |=> state_q != ST_T1);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/bus_data_path.sv
module bus_data_path
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  cyc_type_e         ctype_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] din_i,
  input  bus_state_e        state_i,
  input  logic [DATA_W-1:0] status_i,
  output cyc_type_e         ctype_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sync_o,
  output logic              dbin_o,
  output logic              wait_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_instr_o
);
  cyc_type_e         ctype_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              instr_q;
  logic              data_phase, capture_en;

  assign data_phase = (state_i == ST_T2) || (state_i == ST_TW) || (state_i == ST_T3);
  assign capture_en = (state_i == ST_T3) && takes_data(ctype_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctype_q <= CT_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      ctype_q <= ctype_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      instr_q <= 1'b0;
    end else if (capture_en) begin
      rdata_q <= din_i;
      instr_q <= (ctype_q == CT_FETCH);
    end
  end

  always_comb begin
    sync_o    = (state_i == ST_T1);
    wait_o    = (state_i == ST_TW);
    dbin_o    = data_phase && uses_dbin(ctype_q);
    dout_oe_o = 1'b0;
    dout_o    = '0;
    if (state_i == ST_T1) begin
      dout_oe_o = 1'b1;
      dout_o    = status_i;
    end else if (data_phase && is_write(ctype_q)) begin
      dout_oe_o = 1'b1;
      dout_o    = wdata_q;
    end
  end

  assign ctype_o       = ctype_q;
  assign addr_o        = addr_q;
  assign rdata_o       = rdata_q;
  assign rdata_instr_o = instr_q;

  p_no_drive_while_reading_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dbin_o |-> !dout_oe_o);
  p_dbin_stretched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dbin_o && wait_o |=> dbin_o);
  p_write_keeps_rdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_i == ST_T3 && is_write(ctype_q) |=> $stable(rdata_q) && $stable(instr_q));
  p_sync_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |-> !dbin_o && !wait_o);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        ctype_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sync_o,
  output logic              dbin_o,
  output logic              wait_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_instr_o
);
  bus_state_e        state;
  logic              accept;
  cyc_type_e         ctype_q;
  logic [DATA_W-1:0] status;

  bus_cyc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ready_i  (ready_i),
    .state_o  (state),
    .accept_o (accept),
    .done_o   (done_o)
  );

  bus_status_enc #(.DATA_W(DATA_W)) u_enc (
    .ctype_i  (ctype_q),
    .status_o (status)
  );

  bus_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept_i      (accept),
    .ctype_i       (cyc_type_e'(ctype_i)),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .din_i         (din_i),
    .state_i       (state),
    .status_i      (status),
    .ctype_o       (ctype_q),
    .addr_o        (addr_o),
    .sync_o        (sync_o),
    .dbin_o        (dbin_o),
    .wait_o        (wait_o),
    .dout_o        (dout_o),
    .dout_oe_o     (dout_oe_o),
    .rdata_o       (rdata_o),
    .rdata_instr_o (rdata_instr_o)
  );

  p_sync_one_clock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o |=> !sync_o);
  p_dbin_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dbin_o |-> uses_dbin(ctype_q));
  p_done_after_t3_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !sync_o && !dbin_o && !wait_o && !dout_oe_o);
endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [2:0]    ctype_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          ready_i = 1'b1;
  logic [DW-1:0] din_i = '0;
  logic [AW-1:0] addr_o;
  logic          sync_o, dbin_o, wait_o, dout_oe_o, done_o, rdata_instr_o;
  logic [DW-1:0] dout_o, rdata_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_rd = '0;
  logic          exp_ins = 1'b0;

  always #4 clk = ~clk;

  bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctype_i(ctype_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .ready_i(ready_i), .din_i(din_i),
    .addr_o(addr_o), .sync_o(sync_o), .dbin_o(dbin_o), .wait_o(wait_o),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o), .done_o(done_o),
    .rdata_o(rdata_o), .rdata_instr_o(rdata_instr_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic wr_kind(int t);
    return t == 2 || t == 4 || t == 6;
  endfunction
  function automatic logic dbin_kind(int t);
    return t == 0 || t == 1 || t == 3 || t == 7;
  endfunction
  function automatic logic [7:0] stat_of(int t);
    logic [7:0] s;
    s = 8'h00;
    if (t == 7) s = s + 8'h01;
    if (!wr_kind(t)) s = s + 8'h02;
    if (t == 3 || t == 4) s = s + 8'h04;
    if (t == 6) s = s + 8'h10;
    if (t == 0 || t == 7) s = s + 8'h20;
    if (t == 5) s = s + 8'h40;
    if (t == 0 || t == 1 || t == 3) s = s + 8'h80;
    return s;
  endfunction

  task automatic run_cycle(input int t, input int n);
    logic [AW-1:0] a;
    logic [DW-1:0] w, d;
    a = AW'(16'h1000 + t * 16'h0111 + n);
    w = DW'(8'h30 + t * 8'h11 + n);
    d = DW'(8'hC5 ^ (t * 8'h13 + n * 8'h07));
    @(negedge clk);
    start_i = 1'b1; ctype_i = 3'(t); addr_i = a; wdata_i = w; ready_i = 1'b1;
    for (int i = 0; i <= 3 + n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (i == 0) begin
        chk(sync_o == 1'b1, "R2 sync in T1", 32'(sync_o), 1);
        chk(dout_oe_o == 1'b1 && dout_o == stat_of(t), "R2 status byte", 32'(dout_o), 32'(stat_of(t)));
        chk(addr_o == a, "R1 address", 32'(addr_o), 32'(a));
        chk(dbin_o == 1'b0 && wait_o == 1'b0, "R4 T1 quiet", 32'({dbin_o, wait_o}), 0);
      end else if (i <= 2 + n) begin
        chk(sync_o == 1'b0, "R2 sync low", 32'(sync_o), 0);
        chk(wait_o == (i >= 2 && i <= 1 + n), "R5 wait", 32'(wait_o), 32'(i >= 2 && i <= 1 + n));
        chk(dbin_o == dbin_kind(t), "R4 dbin", 32'(dbin_o), 32'(dbin_kind(t)));
        if (wr_kind(t))
          chk(dout_oe_o == 1'b1 && dout_o == w, "R3 write data", 32'({dout_oe_o, dout_o}), 32'({1'b1, w}));
        else
          chk(dout_oe_o == 1'b0, "R8 lines float", 32'(dout_oe_o), 0);
        chk(done_o == 1'b0, "R1 no early done", 32'(done_o), 0);
        if (i == 1 && (n % 2 == 1)) begin
          start_i = 1'b1; ctype_i = 3'((t + 3) % 8);
        end
      end else begin
        chk(done_o == 1'b1, "R1 done timing", 32'(done_o), 1);
        chk(dbin_o == 1'b0 && dout_oe_o == 1'b0 && sync_o == 1'b0, "R8 idle lines",
            32'({dbin_o, dout_oe_o, sync_o}), 0);
        if (!wr_kind(t)) begin
          exp_rd = d;
          exp_ins = (t == 0);
          chk(rdata_o == exp_rd, "R6 captured byte", 32'(rdata_o), 32'(exp_rd));
          chk(rdata_instr_o == exp_ins, "R6 instruction flag", 32'(rdata_instr_o), 32'(exp_ins));
        end else begin
          chk(rdata_o == exp_rd && rdata_instr_o == exp_ins, "R7 rdata kept",
              32'({rdata_instr_o, rdata_o}), 32'({exp_ins, exp_rd}));
        end
      end
      ready_i = !(i >= 1 && i < 1 + n);
      din_i = (i == 2 + n) ? d : ~d;
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one clock", 32'(done_o), 0);
    chk(sync_o == 1'b0, "R9 busy start ignored", 32'(sync_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sync_o == 0 && dbin_o == 0 && wait_o == 0 && dout_oe_o == 0 && done_o == 0 && rdata_o == 0,
        "R10 reset state", 32'({sync_o, dbin_o, wait_o, dout_oe_o, done_o}), 0);
    rst_n = 1'b1;
    for (int t = 0; t < 8; t++)
      for (int n = 0; n < 4; n++)
        run_cycle(t, n);
    @(negedge clk);
    start_i = 1'b1; ctype_i = 3'd1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(sync_o == 0 && dbin_o == 0 && wait_o == 0 && dout_oe_o == 0 && done_o == 0,
        "R10 reset mid-cycle", 32'({sync_o, dbin_o, wait_o, dout_oe_o, done_o}), 0);
    chk(rdata_o == 0, "R10 rdata cleared", 32'(rdata_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sync_o == 0 && dbin_o == 0, "R10 stays idle", 32'({sync_o, dbin_o}), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule